// File: doc/BRIEF.md
# Graphics Command Ring Pointer Controller

This block keeps the bookkeeping for a circular command ring that lives in system memory and feeds a graphics command processor. The processor side pushes 32-byte bursts into the ring; each burst moves the producer pointer on by one line. The graphics side pulls lines out through a request/grant fetch port; each granted request hands out one 32-byte line address and moves the consumer pointer on by one line. Both pointers wrap inside a window set by a base address and an inclusive last-line address. The block keeps the number of bytes between the two pointers and sets sticky status flags when that count rises above a high mark or drops below a low mark. A consumer-pointer breakpoint can stop fetching at a chosen line. One interrupt line combines the enabled conditions.

Software reaches every register through a 16-bit write/read bus. Addresses are halfword indices, and each 32-bit quantity is split into a low half and a high half. The fetch port is driven by a three-state machine. FS_IDLE waits for work. It moves to FS_REQ when fetching is enabled, the pointers differ and no breakpoint matches. It moves to FS_HALT when those conditions hold apart from a breakpoint match. FS_REQ asserts `fetch_req` and returns to FS_IDLE on a grant, or when its conditions lapse. FS_HALT returns to FS_IDLE as soon as the breakpoint no longer matches.

Register map (halfword index): 0 control, 1 status, 2 clear, 3/4 base, 5/6 last line, 7/8 high mark, 9/10 low mark, 11/12 breakpoint, 13/14 distance, 15/16 producer pointer, 17/18 consumer pointer (low half at the even-odd index given first). Control bits: [0] fetch enable, [1] breakpoint enable, [2] overflow interrupt enable, [3] underflow interrupt enable, [4] burst link enable, [5] breakpoint interrupt enable. Status bits: [0] overflow, [1] underflow, [2] read idle, [3] command idle, [4] breakpoint.

Top module: `cmdq_ctrl`

## Requirements
- R1: While reset is held and after its release, both pointers, the distance, all address registers and control read 0, status reads 0x000C and `irq` and `fetch_req` are low.
- R2: Writes to the low halves of base (3), last line (5), breakpoint (11), distance (13), producer (15) and consumer (17) store the data ANDed with 0xFFE0. High halves and both marks (7 to 10) store all 16 bits. Control (0) keeps bits [5:0]. Clear (2) and any unmapped index read 0.
- R3: A pointer that advances from the last-line address is loaded with the base address. Otherwise it grows by 32.
- R4: A `burst_in` pulse with control bit 4 set advances the producer pointer and adds 32 to the distance. With bit 4 clear it changes nothing.
- R5: `fetch_req` is high only while control bit 0 is set, the pointers differ and no breakpoint matches, and `fetch_addr` then equals the consumer pointer. A cycle with `fetch_req` and `fetch_gnt` both high completes one line: the consumer pointer advances and the distance drops by 32.
- R6: Once the fetch conditions hold, `fetch_req` rises within two cycles.
- R7: A breakpoint matches when control bit 1 is set and the consumer pointer equals the breakpoint register. Status bit 4 sets on the edge after the updated consumer pointer matches and stays set while bit 1 stays set. It clears on the first edge where bit 1 was low.
- R8: Status bit 0 sets on any edge where the updated distance exceeds the high mark, and it holds until it is cleared.
- R9: Status bit 1 sets on any edge where the updated distance is below the low mark, and it holds until it is cleared.
- R10: Writing the clear register with bit 0 set clears status bit 0, and with bit 1 set clears status bit 1. Other bits have no effect. If the condition still holds on that edge, the flag stays set.
- R11: Status bit 2 equals (consumer pointer == producer pointer). Status bit 3 always reads 1.
- R12: `irq` is high exactly when (status bit 4 and control bit 5), (status bit 0 and control bit 2) or (status bit 1 and control bit 3) holds.
- R13: A burst and a completed line in the same cycle leave the distance unchanged. A register write to a half of a pointer or of the distance takes precedence over that cycle's hardware update of the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Halfword register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| burst_in | input | 1 | One pulse per 32-byte processor burst written into the ring |
| fetch_req | output | 1 | Fetch port request |
| fetch_gnt | input | 1 | Fetch port grant |
| fetch_addr | output | 32 | Line address of the pending fetch |
| irq | output | 1 | Combined interrupt |

## Verification
The pointer-step properties assume no register write happens in the same cycle as the update they check, so each of them is qualified on `reg_write` being low. The bench still issues such collisions on purpose and leaves them to its reference model, which applies the write-wins rule. The properties also assume the base and last-line registers define a window whose last line is reachable from the base in 32-byte steps. The bench programs such a window before it enables bursts or fetching and never changes it afterwards. The grant may arrive at any time and may stay low for any number of cycles, and the bench varies it randomly.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int unsigned PTR_W      = 32;
    localparam int unsigned HALF_W     = PTR_W / 2;
    localparam int unsigned LINE_BYTES = 32;
    localparam int unsigned REG_AW     = 5;
    localparam int unsigned CTRL_W     = 6;

    localparam logic [HALF_W-1:0] ALIGN_MASK = ~HALF_W'(LINE_BYTES - 1);

    // Halfword register indices
    localparam logic [REG_AW-1:0] RA_CTRL    = 5'd0;
    localparam logic [REG_AW-1:0] RA_STAT    = 5'd1;
    localparam logic [REG_AW-1:0] RA_CLR     = 5'd2;
    localparam logic [REG_AW-1:0] RA_SW_BASE = 5'd3;   // base, last, hi mark, lo mark, breakpoint
    localparam logic [REG_AW-1:0] RA_HW_BASE = 5'd13;  // distance, producer, consumer

    localparam int unsigned NUM_SW = 5;
    localparam int unsigned NUM_HW = 3;

    localparam int unsigned HW_DIST = 0;
    localparam int unsigned HW_WPTR = 1;
    localparam int unsigned HW_RPTR = 2;

    typedef struct packed {
        logic bp_ie;
        logic link_en;
        logic unf_ie;
        logic ovf_ie;
        logic bp_en;
        logic fetch_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_HALT = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [HALF_W-1:0]   reg_wdata,
    output ctrl_t               ctrl,
    output logic [PTR_W-1:0]    base_q,
    output logic [PTR_W-1:0]    last_q,
    output logic [PTR_W-1:0]    hiwm_q,
    output logic [PTR_W-1:0]    lowm_q,
    output logic [PTR_W-1:0]    bkpt_q,
    output logic [HALF_W-1:0]   wdata_al,
    output logic [NUM_HW-1:0]   hw_wr_lo,
    output logic [NUM_HW-1:0]   hw_wr_hi,
    output logic                clr_ovf,
    output logic                clr_unf
);

    // Software-only 32-bit registers, each split into two halfwords
    for (genvar gi = 0; gi < NUM_SW; gi++) begin : g_sw
        localparam logic [REG_AW-1:0] LO_A = RA_SW_BASE + REG_AW'(2 * gi);
        localparam logic [REG_AW-1:0] HI_A = LO_A + REG_AW'(1);
        // the two watermarks keep their low bits
        localparam bit MASK_LO = (gi != 2) && (gi != 3);

        logic [PTR_W-1:0] q_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= '0;
            end else if (reg_we) begin
                if (reg_addr == LO_A) begin
                    q_r[HALF_W-1:0] <= MASK_LO ? (reg_wdata & ALIGN_MASK) : reg_wdata;
                end
                if (reg_addr == HI_A) begin
                    q_r[PTR_W-1:HALF_W] <= reg_wdata;
                end
            end
        end
    end

    assign base_q = g_sw[0].q_r;
    assign last_q = g_sw[1].q_r;
    assign hiwm_q = g_sw[2].q_r;
    assign lowm_q = g_sw[3].q_r;
    assign bkpt_q = g_sw[4].q_r;

    // Write strobes for registers that hardware also updates
    for (genvar gj = 0; gj < NUM_HW; gj++) begin : g_hw
        localparam logic [REG_AW-1:0] LO_A = RA_HW_BASE + REG_AW'(2 * gj);
        localparam logic [REG_AW-1:0] HI_A = LO_A + REG_AW'(1);
        assign hw_wr_lo[gj] = reg_we && (reg_addr == LO_A);
        assign hw_wr_hi[gj] = reg_we && (reg_addr == HI_A);
    end

    assign wdata_al = reg_wdata & ALIGN_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (reg_we && reg_addr == RA_CTRL) begin
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    assign clr_ovf = reg_we && (reg_addr == RA_CLR) && reg_wdata[0];
    assign clr_unf = reg_we && (reg_addr == RA_CLR) && reg_wdata[1];

endmodule

// File: rtl/cmdq_ptr.sv
module cmdq_ptr #(
    parameter int unsigned PTR_W  = 32,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned STEP   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [PTR_W-1:0]   base,
    input  logic [PTR_W-1:0]   last,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [HALF_W-1:0]  wdata_lo,
    input  logic [HALF_W-1:0]  wdata_hi,
    output logic [PTR_W-1:0]   ptr_q,
    output logic [PTR_W-1:0]   ptr_d
);

    always_comb begin
        ptr_d = ptr_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) ptr_d[HALF_W-1:0]     = wdata_lo;
            if (wr_hi) ptr_d[PTR_W-1:HALF_W] = wdata_hi;
        end else if (advance) begin
            ptr_d = (ptr_q == last) ? base : ptr_q + PTR_W'(STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/cmdq_status.sv
module cmdq_status #(
    parameter int unsigned PTR_W  = 32,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned STEP   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               dec,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [HALF_W-1:0]  wdata_lo,
    input  logic [HALF_W-1:0]  wdata_hi,
    input  logic [PTR_W-1:0]   hiwm,
    input  logic [PTR_W-1:0]   lowm,
    input  logic               clr_ovf,
    input  logic               clr_unf,
    input  logic               bp_en,
    input  logic [PTR_W-1:0]   rptr_d,
    input  logic [PTR_W-1:0]   bkpt,
    output logic [PTR_W-1:0]   dist_q,
    output logic               ovf_q,
    output logic               unf_q,
    output logic               bp_q
);

    logic [PTR_W-1:0] dist_d;
    logic             ovf_d;
    logic             unf_d;
    logic             bp_d;

    always_comb begin
        dist_d = dist_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) dist_d[HALF_W-1:0]     = wdata_lo;
            if (wr_hi) dist_d[PTR_W-1:HALF_W] = wdata_hi;
        end else begin
            unique case ({inc, dec})
                2'b10:   dist_d = dist_q + PTR_W'(STEP);
                2'b01:   dist_d = dist_q - PTR_W'(STEP);
                default: dist_d = dist_q;
            endcase
        end
    end

    always_comb begin
        ovf_d = (ovf_q && !clr_ovf) || (dist_d > hiwm);
        unf_d = (unf_q && !clr_unf) || (dist_d < lowm);
        bp_d  = bp_en && (bp_q || (rptr_d == bkpt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dist_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            bp_q   <= 1'b0;
        end else begin
            dist_q <= dist_d;
            ovf_q  <= ovf_d;
            unf_q  <= unf_d;
            bp_q   <= bp_d;
        end
    end

endmodule

// File: rtl/cmdq_fetch_fsm.sv
module cmdq_fetch_fsm
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_en,
    input  logic ptrs_differ,
    input  logic bp_hit,
    input  logic fetch_gnt,
    output logic fetch_req,
    output logic line_done
);

    fetch_state_e state_q;
    fetch_state_e state_d;
    logic         can_fetch;

    assign can_fetch = fetch_en && ptrs_differ && !bp_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (fetch_en && ptrs_differ && bp_hit) state_d = FS_HALT;
                else if (can_fetch)                   state_d = FS_REQ;
            end
            FS_REQ: begin
                if (!can_fetch || fetch_gnt) state_d = FS_IDLE;
            end
            FS_HALT: begin
                if (!bp_hit) state_d = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fetch_req = (state_q == FS_REQ) && can_fetch;
        line_done = fetch_req && fetch_gnt;
    end

endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
    import cmdq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [HALF_W-1:0]   reg_wdata,
    output logic [HALF_W-1:0]   reg_rdata,
    input  logic                burst_in,
    output logic                fetch_req,
    input  logic                fetch_gnt,
    output logic [PTR_W-1:0]    fetch_addr,
    output logic                irq
);

    ctrl_t              ctrl;
    logic [PTR_W-1:0]   base_q, last_q, hiwm_q, lowm_q, bkpt_q;
    logic [HALF_W-1:0]  wdata_al;
    logic [NUM_HW-1:0]  hw_wr_lo, hw_wr_hi;
    logic               clr_ovf, clr_unf;
    logic [PTR_W-1:0]   wptr_q, wptr_d, rptr_q, rptr_d, dist_q;
    logic               ovf_q, unf_q, bp_q;
    logic               burst_ok, line_done, bp_hit;

    cmdq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .ctrl     (ctrl),
        .base_q   (base_q),
        .last_q   (last_q),
        .hiwm_q   (hiwm_q),
        .lowm_q   (lowm_q),
        .bkpt_q   (bkpt_q),
        .wdata_al (wdata_al),
        .hw_wr_lo (hw_wr_lo),
        .hw_wr_hi (hw_wr_hi),
        .clr_ovf  (clr_ovf),
        .clr_unf  (clr_unf)
    );

    assign burst_ok = burst_in && ctrl.link_en;
    assign bp_hit   = ctrl.bp_en && (rptr_q == bkpt_q);

    cmdq_ptr #(.PTR_W(PTR_W), .HALF_W(HALF_W), .STEP(LINE_BYTES)) u_wptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (burst_ok),
        .base    (base_q),
        .last    (last_q),
        .wr_lo   (hw_wr_lo[HW_WPTR]),
        .wr_hi   (hw_wr_hi[HW_WPTR]),
        .wdata_lo(wdata_al),
        .wdata_hi(reg_wdata),
        .ptr_q   (wptr_q),
        .ptr_d   (wptr_d)
    );

    cmdq_ptr #(.PTR_W(PTR_W), .HALF_W(HALF_W), .STEP(LINE_BYTES)) u_rptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (line_done),
        .base    (base_q),
        .last    (last_q),
        .wr_lo   (hw_wr_lo[HW_RPTR]),
        .wr_hi   (hw_wr_hi[HW_RPTR]),
        .wdata_lo(wdata_al),
        .wdata_hi(reg_wdata),
        .ptr_q   (rptr_q),
        .ptr_d   (rptr_d)
    );

    cmdq_status #(.PTR_W(PTR_W), .HALF_W(HALF_W), .STEP(LINE_BYTES)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (burst_ok),
        .dec     (line_done),
        .wr_lo   (hw_wr_lo[HW_DIST]),
        .wr_hi   (hw_wr_hi[HW_DIST]),
        .wdata_lo(wdata_al),
        .wdata_hi(reg_wdata),
        .hiwm    (hiwm_q),
        .lowm    (lowm_q),
        .clr_ovf (clr_ovf),
        .clr_unf (clr_unf),
        .bp_en   (ctrl.bp_en),
        .rptr_d  (rptr_d),
        .bkpt    (bkpt_q),
        .dist_q  (dist_q),
        .ovf_q   (ovf_q),
        .unf_q   (unf_q),
        .bp_q    (bp_q)
    );

    cmdq_fetch_fsm u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (ctrl.fetch_en),
        .ptrs_differ(rptr_q != wptr_q),
        .bp_hit     (bp_hit),
        .fetch_gnt  (fetch_gnt),
        .fetch_req  (fetch_req),
        .line_done  (line_done)
    );

    assign fetch_addr = rptr_q;

    assign irq = (bp_q && ctrl.bp_ie) || (ovf_q && ctrl.ovf_ie) || (unf_q && ctrl.unf_ie);

    always_comb begin
        unique case (reg_addr)
            5'd0:    reg_rdata = HALF_W'(ctrl);
            5'd1:    reg_rdata = HALF_W'({bp_q, 1'b1, (rptr_q == wptr_q), unf_q, ovf_q});
            5'd3:    reg_rdata = base_q[HALF_W-1:0];
            5'd4:    reg_rdata = base_q[PTR_W-1:HALF_W];
            5'd5:    reg_rdata = last_q[HALF_W-1:0];
            5'd6:    reg_rdata = last_q[PTR_W-1:HALF_W];
            5'd7:    reg_rdata = hiwm_q[HALF_W-1:0];
            5'd8:    reg_rdata = hiwm_q[PTR_W-1:HALF_W];
            5'd9:    reg_rdata = lowm_q[HALF_W-1:0];
            5'd10:   reg_rdata = lowm_q[PTR_W-1:HALF_W];
            5'd11:   reg_rdata = bkpt_q[HALF_W-1:0];
            5'd12:   reg_rdata = bkpt_q[PTR_W-1:HALF_W];
            5'd13:   reg_rdata = dist_q[HALF_W-1:0];
            5'd14:   reg_rdata = dist_q[PTR_W-1:HALF_W];
            5'd15:   reg_rdata = wptr_q[HALF_W-1:0];
            5'd16:   reg_rdata = wptr_q[PTR_W-1:HALF_W];
            5'd17:   reg_rdata = rptr_q[HALF_W-1:0];
            5'd18:   reg_rdata = rptr_q[PTR_W-1:HALF_W];
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmdq_ctrl_chk.sv
module cmdq_ctrl_chk
    import cmdq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               burst_in,
    input  logic               fetch_req,
    input  logic               fetch_gnt,
    input  logic [PTR_W-1:0]   fetch_addr,
    input  logic               irq,
    input  ctrl_t              ctrl,
    input  logic [PTR_W-1:0]   rptr_q,
    input  logic [PTR_W-1:0]   wptr_q,
    input  logic [PTR_W-1:0]   base_q,
    input  logic [PTR_W-1:0]   last_q,
    input  logic [PTR_W-1:0]   bkpt_q,
    input  logic               ovf_q,
    input  logic               unf_q,
    input  logic               bp_q
);

    // R5
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (ctrl.fetch_en && (rptr_q != wptr_q) && !(ctrl.bp_en && rptr_q == bkpt_q)));

    // R5
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_addr == rptr_q));

    // R3
    rptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_gnt && !reg_we && rptr_q == last_q) |=> (rptr_q == $past(base_q)));

    // R3
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_gnt && !reg_we && rptr_q != last_q)
            |=> (rptr_q == $past(rptr_q) + PTR_W'(LINE_BYTES)));

    // R4
    burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_in && !ctrl.link_en && !reg_we) |=> $stable(wptr_q));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !reg_we) |=> ovf_q);

    // R9
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !reg_we) |=> unf_q);

    // R7
    bp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.bp_en |=> !bp_q);

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_q && !unf_q && !bp_q) |-> !irq);

    // R2
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_q[4:0] == 5'd0) && (wptr_q[4:0] == 5'd0));

endmodule

bind cmdq_ctrl cmdq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .burst_in  (burst_in),
    .fetch_req (fetch_req),
    .fetch_gnt (fetch_gnt),
    .fetch_addr(fetch_addr),
    .irq       (irq),
    .ctrl      (ctrl),
    .rptr_q    (rptr_q),
    .wptr_q    (wptr_q),
    .base_q    (base_q),
    .last_q    (last_q),
    .bkpt_q    (bkpt_q),
    .ovf_q     (ovf_q),
    .unf_q     (unf_q),
    .bp_q      (bp_q)
);

// File: tb/tb_cmdq_ctrl.sv
module tb_cmdq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        burst_in;
    logic        fetch_req;
    logic        fetch_gnt;
    logic [31:0] fetch_addr;
    logic        irq;

    always #10 clk = ~clk;

    cmdq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .burst_in  (burst_in),
        .fetch_req (fetch_req),
        .fetch_gnt (fetch_gnt),
        .fetch_addr(fetch_addr),
        .irq       (irq)
    );

    localparam logic [15:0] MASK = 16'hFFE0;

    int n_run  = 0;
    int n_fail = 0;
    int nopend = 0;
    bit g_def  = 1'b1;

    // behavioural model state
    logic [5:0]  m_ctrl;
    logic [31:0] m_base, m_end, m_hi, m_lo, m_bk, m_dist, m_w, m_r;
    bit          m_ovf, m_unf, m_bp;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [4:0] a);
        case (a)
            5'd0:    return {10'b0, m_ctrl};
            5'd1:    return {11'b0, m_bp, 1'b1, (m_r == m_w), m_unf, m_ovf};
            5'd3:    return m_base[15:0];
            5'd4:    return m_base[31:16];
            5'd5:    return m_end[15:0];
            5'd6:    return m_end[31:16];
            5'd7:    return m_hi[15:0];
            5'd8:    return m_hi[31:16];
            5'd9:    return m_lo[15:0];
            5'd10:   return m_lo[31:16];
            5'd11:   return m_bk[15:0];
            5'd12:   return m_bk[31:16];
            5'd13:   return m_dist[15:0];
            5'd14:   return m_dist[31:16];
            5'd15:   return m_w[15:0];
            5'd16:   return m_w[31:16];
            5'd17:   return m_r[15:0];
            5'd18:   return m_r[31:16];
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'd1:         return "R7/R8/R9/R11 status";
            5'd13, 5'd14: return "R13/R4/R5 distance";
            5'd15, 5'd16: return "R4/R3 producer";
            5'd17, 5'd18: return "R3/R5 consumer";
            default:      return "R2 register";
        endcase
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] p);
        return (p == m_end) ? m_base : p + 32'd32;
    endfunction

    task automatic step(input bit we, input logic [4:0] a, input logic [15:0] d,
                        input bit b, input bit g);
        bit          canf, fire, bok, clr0, clr1, m_irq;
        logic [31:0] w_n, r_n, d_n;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; burst_in = b; fetch_gnt = g;
        #1;
        if (!rst_n) begin
            chk("R1 reset read", {16'b0, reg_rdata}, {16'b0, m_read(a)});
            chk("R1 reset irq", {31'b0, irq}, 32'd0);
            chk("R1 reset request", {31'b0, fetch_req}, 32'd0);
            return;
        end
        if (!we) chk(tag_of(a), {16'b0, reg_rdata}, {16'b0, m_read(a)});
        m_irq = (m_bp && m_ctrl[5]) || (m_ovf && m_ctrl[2]) || (m_unf && m_ctrl[3]);
        chk("R12 irq", {31'b0, irq}, {31'b0, m_irq});
        canf = m_ctrl[0] && (m_r != m_w) && !(m_ctrl[1] && m_r == m_bk);
        if (fetch_req) begin
            chk("R5 request gate", {31'b0, canf}, 32'd1);
            chk("R5 fetch address", fetch_addr, m_r);
        end
        if (canf && !fetch_req) nopend++;
        else                    nopend = 0;
        if (canf) chk("R6 request latency", {31'b0, (nopend <= 2)}, 32'd1);
        fire = fetch_req && g;
        bok  = b && m_ctrl[4];
        // next producer
        w_n = m_w;
        if (we && a == 5'd15)      w_n[15:0]  = d & MASK;
        else if (we && a == 5'd16) w_n[31:16] = d;
        else if (bok)              w_n = adv(m_w);
        // next consumer
        r_n = m_r;
        if (we && a == 5'd17)      r_n[15:0]  = d & MASK;
        else if (we && a == 5'd18) r_n[31:16] = d;
        else if (fire)             r_n = adv(m_r);
        // next distance
        d_n = m_dist;
        if (we && a == 5'd13)      d_n[15:0]  = d & MASK;
        else if (we && a == 5'd14) d_n[31:16] = d;
        else                       d_n = m_dist + (bok ? 32'd32 : 32'd0) - (fire ? 32'd32 : 32'd0);
        clr0 = we && a == 5'd2 && d[0];
        clr1 = we && a == 5'd2 && d[1];
        m_ovf = (m_ovf && !clr0) || (d_n > m_hi);
        m_unf = (m_unf && !clr1) || (d_n < m_lo);
        m_bp  = m_ctrl[1] ? (m_bp || (r_n == m_bk)) : 1'b0;
        m_w = w_n; m_r = r_n; m_dist = d_n;
        if (we) begin
            case (a)
                5'd0:  m_ctrl = d[5:0];
                5'd3:  m_base[15:0]  = d & MASK;
                5'd4:  m_base[31:16] = d;
                5'd5:  m_end[15:0]   = d & MASK;
                5'd6:  m_end[31:16]  = d;
                5'd7:  m_hi[15:0]    = d;
                5'd8:  m_hi[31:16]   = d;
                5'd9:  m_lo[15:0]    = d;
                5'd10: m_lo[31:16]   = d;
                5'd11: m_bk[15:0]    = d & MASK;
                5'd12: m_bk[31:16]   = d;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        step(1'b1, a, d, 1'b0, g_def);
    endtask

    task automatic rd(input logic [4:0] a, input int n);
        for (int i = 0; i < n; i++) step(1'b0, a, 16'h0, 1'b0, g_def);
    endtask

    task automatic burst(input int n, input logic [4:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 16'h0, 1'b1, g_def);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit          rb, rg;
        int          ra;
        logic [15:0] cv;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        burst_in = 1'b0; fetch_gnt = 1'b0;
        m_ctrl = '0; m_base = '0; m_end = '0; m_hi = '0; m_lo = '0; m_bk = '0;
        m_dist = '0; m_w = '0; m_r = '0; m_ovf = 1'b0; m_unf = 1'b0; m_bp = 1'b0;

        // R1: reset state
        step(1'b0, 5'd1, 16'h0, 1'b0, 1'b0);
        step(1'b0, 5'd0, 16'h0, 1'b0, 1'b0);
        step(1'b0, 5'd15, 16'h0, 1'b0, 1'b0);
        step(1'b0, 5'd13, 16'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        rd(5'd1, 2);
        rd(5'd17, 1);

        // R2: window setup with alignment masking
        wr(5'd3, 16'h101F); wr(5'd4, 16'h0002);
        wr(5'd5, 16'h10FF); wr(5'd6, 16'h0002);
        wr(5'd15, 16'h1007); wr(5'd16, 16'h0002);
        wr(5'd17, 16'h1000); wr(5'd18, 16'h0002);
        wr(5'd7, 16'h00A5);
        wr(5'd9, 16'h0021);           // R9: distance 0 is below 33
        for (int k = 0; k <= 19; k++) rd(5'(k), 1);

        // R4: bursts ignored without link enable
        burst(2, 5'd15);
        rd(5'd13, 1);

        // R4/R3/R8: linked bursts up to the last line
        wr(5'd0, 16'h0010);
        burst(7, 5'd15);
        rd(5'd1, 1); rd(5'd13, 1);

        // R10: non-clear bits ignored, underflow clear, overflow stays
        wr(5'd2, 16'hFFFC); rd(5'd1, 1);
        wr(5'd2, 16'h0002); rd(5'd1, 1);
        wr(5'd2, 16'h0001); rd(5'd1, 1);

        // R5/R3/R12: drain with fetch on and overflow interrupt enabled
        wr(5'd0, 16'h0015);
        rd(5'd17, 20);
        rd(5'd1, 2);
        wr(5'd2, 16'h0001); rd(5'd1, 2);

        // R7: breakpoint halts fetch while bursts continue (R13 overlap)
        wr(5'd11, 16'h1040); wr(5'd12, 16'h0002);
        wr(5'd0, 16'h0033);
        burst(6, 5'd17);
        rd(5'd1, 6); rd(5'd17, 2);
        wr(5'd0, 16'h0031);
        rd(5'd1, 2); rd(5'd17, 12);

        // R5: grant held low keeps the request pending
        g_def = 1'b0;
        burst(2, 5'd17);
        rd(5'd17, 4);
        g_def = 1'b1;
        rd(5'd13, 6);

        // R13: register write beats a simultaneous hardware update
        step(1'b1, 5'd13, 16'h0047, 1'b1, 1'b1);
        rd(5'd13, 2);
        step(1'b1, 5'd15, 16'h1080, 1'b1, 1'b1);
        rd(5'd15, 2);
        rd(5'd13, 8);

        // randomised traffic against the model
        for (int i = 0; i < 500; i++) begin
            rb = ($urandom_range(0, 2) == 0);
            rg = ($urandom_range(0, 3) != 0);
            ra = $urandom_range(0, 19);
            if ($urandom_range(0, 15) == 0) begin
                step(1'b1, 5'd2, 16'($urandom_range(0, 3)), rb, rg);
            end else if ($urandom_range(0, 40) == 0) begin
                case ($urandom_range(0, 3))
                    0:       cv = 16'h001D;
                    1:       cv = 16'h0015;
                    2:       cv = 16'h003F;
                    default: cv = 16'h0011;
                endcase
                step(1'b1, 5'd0, cv, rb, rg);
            end else begin
                step(1'b0, 5'(ra), 16'h0, rb, rg);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule